// File: doc/BRIEF.md
# Page Command Sequencer for a Voice Store-and-Replay Codec

This block sits between the command decoder of a speech recorder and its DRAM controller. It accepts two kinds of operation: a page command, which stores into or replays from one page of DRAM depending on the codec direction bit, and a wait command, which runs for the same length without touching memory. Every operation lasts a fixed number of codec bit periods. The bit period comes from dividing the master clock by one of two ratios, chosen by a rate bit. While an operation runs, the block issues one single-bit memory access per bit period and walks the page in ascending bit order.

Command intake goes through a one-deep holding register. A command that arrives while the sequencer is idle starts on the next cycle. A command that arrives during an operation waits and takes over on the very cycle the running operation ends, so operations follow each other with no gap. A newer command replaces one that is still waiting. The block keeps a status byte that holds an attention flag, a holding-register-empty bit, an idle bit and a 5-bit input power reading. It drives an open-drain interrupt request. It also tells the codec when to send an alternating idle pattern in place of audio.

Top module: `pgseq_top`

## Requirements
- R1: An operation lasts exactly PAGE_LEN bit periods. A page command makes exactly one `mem_req` per bit period, with `mem_addr` = {page number, bit index} and the bit index rising from 0. A wait command makes no `mem_req`.
- R2: `bit_tick` is a one-cycle strobe that repeats every DIV_HI clocks when `rate_hi` is 1 and every DIV_LO clocks when `rate_hi` is 0 (defaults 64 and 128).
- R3: A command goes into the holding register on the cycle after its strobe. It starts one cycle later if nothing is running. Otherwise it starts on the cycle the running operation ends, and `status[5]` stays 0 between the two operations.
- R4: The holding register holds one command. A second command that arrives before the first one starts replaces it, and the replaced command never runs. When `wait_cmd` and `page_cmd` are both set, the wait is taken.
- R5: Status layout: bit 7 is the flag, bit 6 is holding-register empty, bit 5 is idle, and bits 4..0 are power. After `rst` the status byte is 8'h60.
- R6: The flag is set on the cycle after bit 6 or bit 5 rises, unless the rise came from `gen_rst`. It is cleared on the cycle after a `stat_rd` pulse or a `gen_rst`, and a rise takes precedence over a read in the same cycle.
- R7: `irq_drive_low` is 1 only while the flag is 1 and `irq_en` is 1.
- R8: `idle_pat_en` is 1 when `decode` is 1, `powersave` is 0, and either nothing is running or a wait is running. During a store with `decode`=0 and `powersave`=1, `mem_fill_idle` is 1 and `idle_bit` is 1 at even bit indices and 0 at odd ones. `mem_write` is the inverse of `decode`.
- R9: `gen_rst` stops the running operation, drops the held command, clears the flag, and sets bits 6 and 5. No access follows it.
- R10: When `decode` is 0, the power field loads `pwr_in` at the end of each operation, saturated at 31. Otherwise the field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| gen_rst | input | 1 | General reset command strobe |
| page_cmd | input | 1 | Page (store/replay) command strobe |
| wait_cmd | input | 1 | Wait command strobe |
| page_num | input | 12 | Page number for a page command |
| irq_en | input | 1 | Interrupt enable mode bit |
| rate_hi | input | 1 | 1 selects the fast bit rate |
| decode | input | 1 | 1 = replay direction, 0 = store direction |
| powersave | input | 1 | Codec powersave mode bit |
| stat_rd | input | 1 | Status read strobe |
| pwr_in | input | 8 | Input level count from the codec |
| bit_tick | output | 1 | Bit period strobe |
| mem_req | output | 1 | One-bit DRAM access request |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 12+log2(PAGE_LEN) | {page, bit index} |
| mem_fill_idle | output | 1 | Write the idle pattern instead of codec data |
| idle_pat_en | output | 1 | Codec sends the idle pattern |
| idle_bit | output | 1 | Current idle pattern bit |
| status | output | 8 | Status byte |
| irq_drive_low | output | 1 | Enable for the open-drain interrupt pull-down |

## Verification
Single replays, stores and waits on random pages, in random directions and with random power counts, confirm the operation length, the address walk and the power saturation. Each pattern distinguishes a wait from a page command by its access count. Three commands back to back, the third arriving while the second still waits, separate gapless hand-over from a late start, and an overwritten held command from a queued one. A powersaved store, a wait in replay direction and a general reset during a busy period with a command held cover the idle pattern outputs and the flag suppression that apply only in those cases.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
    localparam int PAGE_W   = 12;
    localparam int PWR_W    = 5;
    localparam int PWR_IN_W = 8;

    typedef enum logic {
        OP_PAGE = 1'b0,
        OP_WAIT = 1'b1
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [PAGE_W-1:0] page;
    } cmd_t;

    typedef struct packed {
        logic             flag;
        logic             empty;
        logic             idle;
        logic [PWR_W-1:0] pwr;
    } stat_t;

    function automatic logic [PWR_W-1:0] clamp_pwr(input logic [PWR_IN_W-1:0] v);
        if (v > PWR_IN_W'((1 << PWR_W) - 1))
            return '1;
        return v[PWR_W-1:0];
    endfunction
endpackage

// File: rtl/pgseq_bitclk.sv
module pgseq_bitclk #(
    parameter int DIV_HI = 64,
    parameter int DIV_LO = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_hi,
    output logic tick
);
    localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW   = $clog2(DMAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb lim = rate_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);

    // Compare with >= so a switch to the short ratio never overruns.
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/pgseq_exec.sv
module pgseq_exec
    import pgseq_pkg::*;
#(
    parameter  int PAGE_LEN = 1024,
    localparam int BW       = $clog2(PAGE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gen_rst,
    input  logic          load,
    input  cmd_t          load_cmd,
    input  logic          tick,
    output logic          active,
    output logic          pend_valid,
    output cmd_t          act_cmd,
    output logic [BW-1:0] bit_idx,
    output logic          done
);
    cmd_t pend_cmd;
    logic take;

    assign done = active && tick && (bit_idx == BW'(PAGE_LEN - 1));
    // Held command moves on when idle or on the final bit of the running one.
    assign take = pend_valid && (!active || done);

    always_ff @(posedge clk) begin
        if (rst || gen_rst) begin
            active     <= 1'b0;
            pend_valid <= 1'b0;
            bit_idx    <= '0;
            act_cmd    <= '0;
            pend_cmd   <= '0;
        end else begin
            if (take) begin
                active  <= 1'b1;
                act_cmd <= pend_cmd;
                bit_idx <= '0;
            end else if (done) begin
                active  <= 1'b0;
                bit_idx <= '0;
            end else if (active && tick) begin
                bit_idx <= bit_idx + BW'(1);
            end

            if (load) begin
                pend_valid <= 1'b1;
                pend_cmd   <= load_cmd;
            end else if (take) begin
                pend_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgseq_status.sv
module pgseq_status
    import pgseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                gen_rst,
    input  logic                stat_rd,
    input  logic                empty,
    input  logic                idle,
    input  logic                pwr_strobe,
    input  logic [PWR_IN_W-1:0] pwr_in,
    input  logic                irq_en,
    output stat_t               status,
    output logic                irq_drive_low
);
    logic             empty_q, idle_q, flag;
    logic [PWR_W-1:0] pwr;
    logic             rise;

    assign rise = (empty && !empty_q) || (idle && !idle_q);

    always_ff @(posedge clk) begin
        if (rst || gen_rst) begin
            // Delayed copies preset high so the reset-forced rise is not seen.
            flag    <= 1'b0;
            empty_q <= 1'b1;
            idle_q  <= 1'b1;
        end else begin
            empty_q <= empty;
            idle_q  <= idle;
            if (rise)         flag <= 1'b1;
            else if (stat_rd) flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             pwr <= '0;
        else if (pwr_strobe) pwr <= clamp_pwr(pwr_in);
    end

    assign status        = '{flag: flag, empty: empty, idle: idle, pwr: pwr};
    assign irq_drive_low = flag && irq_en;
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
    import pgseq_pkg::*;
#(
    parameter  int DIV_HI   = 64,
    parameter  int DIV_LO   = 128,
    parameter  int PAGE_LEN = 1024,
    localparam int BW       = $clog2(PAGE_LEN),
    localparam int AW       = PAGE_W + BW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gen_rst,
    input  logic                page_cmd,
    input  logic                wait_cmd,
    input  logic [PAGE_W-1:0]   page_num,
    input  logic                irq_en,
    input  logic                rate_hi,
    input  logic                decode,
    input  logic                powersave,
    input  logic                stat_rd,
    input  logic [PWR_IN_W-1:0] pwr_in,
    output logic                bit_tick,
    output logic                mem_req,
    output logic                mem_write,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_fill_idle,
    output logic                idle_pat_en,
    output logic                idle_bit,
    output logic [7:0]          status,
    output logic                irq_drive_low
);
    cmd_t          load_cmd, act_cmd;
    logic          load, active, pend_valid, done, phase, is_wait;
    logic [BW-1:0] bit_idx;
    stat_t         stat;

    assign load          = page_cmd || wait_cmd;
    assign load_cmd.op   = wait_cmd ? OP_WAIT : OP_PAGE;
    assign load_cmd.page = page_num;

    pgseq_bitclk #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_bitclk (
        .clk(clk), .rst(rst), .rate_hi(rate_hi), .tick(bit_tick)
    );

    pgseq_exec #(.PAGE_LEN(PAGE_LEN)) u_exec (
        .clk(clk), .rst(rst), .gen_rst(gen_rst), .load(load), .load_cmd(load_cmd),
        .tick(bit_tick), .active(active), .pend_valid(pend_valid),
        .act_cmd(act_cmd), .bit_idx(bit_idx), .done(done)
    );

    pgseq_status u_status (
        .clk(clk), .rst(rst), .gen_rst(gen_rst), .stat_rd(stat_rd),
        .empty(!pend_valid), .idle(!active),
        .pwr_strobe(done && !decode && !gen_rst), .pwr_in(pwr_in),
        .irq_en(irq_en), .status(stat), .irq_drive_low(irq_drive_low)
    );

    // Free-running pattern phase for the no-command state.
    always_ff @(posedge clk) begin
        if (rst)           phase <= 1'b1;
        else if (bit_tick) phase <= !phase;
    end

    assign is_wait       = (act_cmd.op == OP_WAIT);
    assign mem_req       = active && !is_wait && bit_tick;
    assign mem_write     = !decode;
    assign mem_addr      = {act_cmd.page, bit_idx};
    assign mem_fill_idle = !decode && powersave;
    assign idle_pat_en   = decode && !powersave && (!active || is_wait);
    assign idle_bit      = active ? !bit_idx[0] : phase;
    assign status        = stat;
endmodule

// File: rtl/pgseq_checks.sv
module pgseq_checks (
    input logic       clk,
    input logic       rst,
    input logic       gen_rst,
    input logic       irq_en,
    input logic       bit_tick,
    input logic       mem_req,
    input logic [7:0] status,
    input logic       irq_drive_low
);
    a_r1_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !status[5]);

    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    a_r6_flag_on_idle_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(status[5]) && !gen_rst && !$past(gen_rst)) |=> status[7]);

    a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq_drive_low |-> (status[7] && irq_en));

    a_r9_genrst_clears: assert property (@(posedge clk) disable iff (rst)
        gen_rst |=> (status[7:5] == 3'b011));

    a_r10_pwr_holds: assert property (@(posedge clk) disable iff (rst)
        !$stable(status[4:0]) |-> $past(!status[5]));
endmodule

bind pgseq_top pgseq_checks u_checks (
    .clk(clk), .rst(rst), .gen_rst(gen_rst), .irq_en(irq_en),
    .bit_tick(bit_tick), .mem_req(mem_req), .status(status),
    .irq_drive_low(irq_drive_low)
);

// File: tb/tb_pgseq_top.sv
`timescale 1ns/1ps
module tb_pgseq_top;
    localparam int DH = 4;
    localparam int DL = 8;
    localparam int PL = 16;
    localparam int AW = 16;

    logic clk = 1'b0, rst = 1'b1, gen_rst = 1'b0, page_cmd = 1'b0, wait_cmd = 1'b0;
    logic [11:0] page_num = '0;
    logic irq_en = 1'b0, rate_hi = 1'b0, decode = 1'b0, powersave = 1'b0, stat_rd = 1'b0;
    logic [7:0] pwr_in = '0;
    logic bit_tick, mem_req, mem_write, mem_fill_idle, idle_pat_en, idle_bit, irq_drive_low;
    logic [AW-1:0] mem_addr;
    logic [7:0] status;

    int checks = 0, errors = 0;

    always #2 clk = !clk;

    pgseq_top #(.DIV_HI(DH), .DIV_LO(DL), .PAGE_LEN(PL)) dut (
        .clk(clk), .rst(rst), .gen_rst(gen_rst), .page_cmd(page_cmd), .wait_cmd(wait_cmd),
        .page_num(page_num), .irq_en(irq_en), .rate_hi(rate_hi), .decode(decode),
        .powersave(powersave), .stat_rd(stat_rd), .pwr_in(pwr_in), .bit_tick(bit_tick),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_fill_idle(mem_fill_idle), .idle_pat_en(idle_pat_en), .idle_bit(idle_bit),
        .status(status), .irq_drive_low(irq_drive_low)
    );

    function automatic int exp_pwr(input int v);
        return (v > 31) ? 31 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input bit w, input int pg);
        page_num = 12'(pg);
        wait_cmd = w;
        page_cmd = !w;
        step();
        page_cmd = 1'b0;
        wait_cmd = 1'b0;
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
    endtask

    // Observe one busy period; expects status[5]==0 on entry.
    task automatic run_out(input int pg0, input int pg1, output int nt, output int nr,
                           output int bad, output int pat, output int cyc);
        nt = 0; nr = 0; bad = 0; pat = 0; cyc = 0;
        while (status[5] == 1'b0) begin
            cyc++;
            if (idle_pat_en) pat++;
            if (bit_tick) nt++;
            if (mem_req) begin
                int ep = (nr < PL) ? pg0 : pg1;
                int ix = nr % PL;
                if (mem_addr != AW'(ep * PL + ix)) bad++;
                if (mem_fill_idle && (idle_bit != ((ix % 2) == 0))) bad++;
                if (mem_write != !decode) bad++;
                nr++;
            end
            step();
        end
    endtask

    task automatic measure_period(output int n);
        while (!bit_tick) step();
        n = 0;
        do begin
            step();
            n++;
        end while (!bit_tick);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nt, nr, bad, pat, cyc, n, ep;
        void'($urandom(32'h5eed_0812));
        repeat (3) step();
        rst = 1'b0;
        step();

        // R5 reset state
        chk(status == 8'h60, "R5 reset status", status, 8'h60);
        chk(irq_drive_low == 1'b0, "R7 irq after reset", irq_drive_low, 0);
        decode = 1'b1;
        step();
        chk(idle_pat_en == 1'b1, "R8 idle pattern with no command", idle_pat_en, 1);

        // R2 divider ratios
        rate_hi = 1'b1;
        step();
        measure_period(n);
        chk(n == DH, "R2 fast period", n, DH);
        rate_hi = 1'b0;
        step();
        measure_period(n);
        measure_period(n);
        chk(n == DL, "R2 slow period", n, DL);

        // R3 start from idle, R1 replay walk
        issue(1'b0, 12'h123);
        chk(status[6:5] == 2'b01, "R3 held then not yet running", status[6:5], 1);
        step();
        chk(status[6:5] == 2'b10, "R3 started next cycle", status[6:5], 2);
        step();
        chk(status[7] == 1'b1, "R6 flag on empty rise", status[7], 1);
        read_status();
        chk(status[7] == 1'b0, "R6 flag cleared by read", status[7], 0);
        run_out(12'h123, 12'h123, nt, nr, bad, pat, cyc);
        chk(nt == PL, "R1 length in bit periods", nt, PL);
        chk(nr == PL && bad == 0, "R1 replay accesses", nr + 100 * bad, PL);
        chk(pat == 0, "R8 no pattern while replaying", pat, 0);
        step();
        chk(status[7] == 1'b1, "R6 flag on idle rise", status[7], 1);
        irq_en = 1'b1;
        step();
        chk(irq_drive_low == 1'b1, "R7 irq pulls low", irq_drive_low, 1);
        read_status();
        chk(irq_drive_low == 1'b0, "R7 irq released after read", irq_drive_low, 0);
        irq_en = 1'b0;

        // R3 gapless hand-over, R4 overwrite
        issue(1'b0, 5);
        step();
        issue(1'b0, 7);
        issue(1'b0, 9);
        chk(status[6] == 1'b0, "R4 held command present", status[6], 0);
        run_out(5, 9, nt, nr, bad, pat, cyc);
        chk(nt == 2 * PL, "R3 no gap between operations", nt, 2 * PL);
        chk(nr == 2 * PL && bad == 0, "R4 overwritten command dropped", nr + 100 * bad, 2 * PL);
        chk(status[6:5] == 2'b11, "R3 empty and idle after chain", status[6:5], 3);

        // R1 wait without access, R8 pattern during wait
        issue(1'b1, 0);
        step();
        run_out(0, 0, nt, nr, bad, pat, cyc);
        chk(nt == PL && nr == 0, "R1 wait makes no access", nr, 0);
        chk(pat == cyc, "R8 pattern through wait", pat, cyc);

        // R10 power latch
        decode = 1'b0;
        pwr_in = 8'd40;
        issue(1'b0, 2);
        step();
        run_out(2, 2, nt, nr, bad, pat, cyc);
        chk(status[4:0] == 5'd31, "R10 power saturates", status[4:0], 31);
        pwr_in = 8'd7;
        issue(1'b1, 0);
        step();
        run_out(0, 0, nt, nr, bad, pat, cyc);
        chk(status[4:0] == 5'd7, "R10 power after wait", status[4:0], 7);
        decode = 1'b1;
        pwr_in = 8'd20;
        issue(1'b0, 3);
        step();
        run_out(3, 3, nt, nr, bad, pat, cyc);
        chk(status[4:0] == 5'd7, "R10 power held in replay", status[4:0], 7);

        // R8 powersaved store fills the idle pattern
        decode = 1'b0;
        powersave = 1'b1;
        pwr_in = 8'd12;
        issue(1'b0, 12'hABC);
        step();
        chk(mem_fill_idle == 1'b1, "R8 fill select", mem_fill_idle, 1);
        run_out(12'hABC, 12'hABC, nt, nr, bad, pat, cyc);
        chk(nr == PL && bad == 0, "R8 stored pattern and addresses", nr + 100 * bad, PL);

        // R9 general reset during a busy period with a held command
        decode = 1'b1;
        powersave = 1'b0;
        issue(1'b0, 1);
        step();
        issue(1'b0, 2);
        repeat (5) step();
        gen_rst = 1'b1;
        step();
        gen_rst = 1'b0;
        chk(status[7:5] == 3'b011, "R9 status after general reset", status[7:5], 3);
        n = 0;
        for (int i = 0; i < 3 * PL * DL; i++) begin
            if (mem_req || status[7] || status[6:5] != 2'b11) n++;
            step();
        end
        chk(n == 0, "R9 nothing resumes and no flag", n, 0);

        // Random single commands against bench expectations
        ep = int'(status[4:0]);
        for (int k = 0; k < 24; k++) begin
            int pg = int'($urandom % 4096);
            bit w = 1'($urandom % 2);
            bit dec = 1'($urandom % 2);
            bit ps = 1'($urandom % 2);
            int pin = int'($urandom % 64);
            decode = dec;
            powersave = ps;
            pwr_in = 8'(pin);
            issue(w, pg);
            step();
            run_out(pg, pg, nt, nr, bad, pat, cyc);
            if (!dec) ep = exp_pwr(pin);
            chk(nt == PL, "R1 random length", nt, PL);
            chk(nr == (w ? 0 : PL) && bad == 0, "R1 random accesses", nr + 100 * bad, w ? 0 : PL);
            chk(int'(status[4:0]) == ep, "R10 random power", status[4:0], ep);
            chk(pat == ((dec && !ps && w) ? cyc : 0), "R8 random pattern", pat,
                (dec && !ps && w) ? cyc : 0);
            step();
            read_status();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule